// File: doc/BRIEF.md
# Configurable 32-pin GPIO port

A memory-mapped general-purpose I/O port. Software reaches it through a single-cycle register bus. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` always shows the register that `reg_addr` selects. Each pin has four configuration bits:

- a direction bit;
- an input-disconnect bit;
- a two-bit pull selection.

The direction bit is one piece of state that three views share: the direction vector, its set and clear aliases, and bit 0 of the pin's configuration word.

For every pin the block combines its own output value, an external driver (driving 0, driving 1, or released) and the pull setting into a registered input level. A keeper holds the last level when nothing else defines it. The block also drives a pin-level output and output-enable for each pin. When the port and an external source drive the same pin, a sticky error bit is set. Software clears it by writing a one.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output vector, input vector, direction vector and error register read 0, and every pin configuration word reads 0x00000002 (input, disconnected, no pull).
- R2: Word offsets: 0 is the output vector, 1 is output-set, 2 is output-clear. A write to offset 0 loads the vector. Offset 1 sets only the bits written as 1, and offset 2 clears only those bits. Offsets 1 and 2 read back the output vector.
- R3: Word offsets: 4 is the direction vector, 5 is direction-set, 6 is direction-clear; all three read the direction vector. The configuration word of pin i is at offset 32+i. A write to offset 4 loads the direction vector. Offsets 5 and 6 set or clear only the bits written as 1. Writing a configuration word updates its pin's direction bit (bit 0). Direction is always identical to bit 0 of the configuration words.
- R4: `pin_oe[i]` equals the pin's direction bit (1 = output). `pin_out[i]` equals the pin's output bit when it is an output and 0 otherwise.
- R5: Configuration bit 1 = 0 connects the input. With the input connected and the external source driving, the input vector (offset 3) shows the external level one cycle later.
- R6: With the input connected, no external drive, and the pin an output, the input vector shows the pin's own output value one cycle later.
- R7: Pull field (configuration bits 3:2) encoding: 3 is pull-up, 1 is pull-down, 0 and 2 are no pull. A connected, undriven input with pull-up reads 1, and with pull-down reads 0.
- R8: A connected, undriven input with no pull keeps the last level the input vector held.
- R9: With the input disconnected (bit 1 = 1), the input bit reads 1 when pull-up is selected and 0 otherwise, whatever the external source does.
- R10: A pin that is an output while the external source drives it sets the error bit (offset 7, bit 0, also on `drive_err`) one cycle later. An input that is externally driven does not set it. The bit stays set after the conflict ends.
- R11: Writing a 1 to bit 0 of offset 7 clears the error bit. Writing 0 leaves it unchanged. A conflict in the same cycle as the clear wins, so the bit stays set.
- R12: Configuration bits 31:4 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| ext_drv_en | input | 32 | External source drives the pin |
| ext_drv_val | input | 32 | Level the external source drives |
| pin_oe | output | 32 | Port output enable per pin |
| pin_out | output | 32 | Port output level per pin |
| drive_err | output | 1 | Sticky drive-conflict flag |

## Verification
The bench targets the shared direction state. A design that kept the direction vector and the configuration bit 0 separately would show stale configuration words after a set, clear or direct write.

It checks the keeper by releasing the external driver. A design without the hold would fall to 0 instead of keeping 1.

It exercises disconnected inputs while the external source drives the opposite level. A design that let the external level through would read the inverse of the pull.

It clears the error while a conflict is still present. A design where clear beat set would read 0 for one cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Register word offsets
    localparam int OFF_OUT    = 0;
    localparam int OFF_OSET   = 1;
    localparam int OFF_OCLR   = 2;
    localparam int OFF_IN     = 3;
    localparam int OFF_DIR    = 4;
    localparam int OFF_DSET   = 5;
    localparam int OFF_DCLR   = 6;
    localparam int OFF_ERR    = 7;
    localparam int CFG_BASE   = 32;

    // Pull selection codes (configuration bits 3:2)
    localparam logic [1:0] PULL_NONE = 2'd0;
    localparam logic [1:0] PULL_DOWN = 2'd1;
    localparam logic [1:0] PULL_ALT  = 2'd2;
    localparam logic [1:0] PULL_UP   = 2'd3;

    // Configuration field positions
    localparam int CFG_DIR_BIT  = 0;
    localparam int CFG_DISC_BIT = 1;
    localparam int CFG_PULL_LO  = 2;
    localparam int CFG_USED     = 4;

    function automatic logic pull_is_up(input logic [1:0] p);
        return p == PULL_UP;
    endfunction

    function automatic logic pull_active(input logic [1:0] p);
        return (p == PULL_UP) || (p == PULL_DOWN);
    endfunction
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir,
    input  logic       out,
    input  logic       disc,
    input  logic [1:0] pull,
    input  logic       ext_en,
    input  logic       ext_val,
    output logic       in_q,
    output logic       clash
);
    logic in_d;

    always_comb begin
        in_d = in_q;
        if (disc) begin
            in_d = pull_is_up(pull);
        end else if (ext_en) begin
            in_d = ext_val;
        end else if (dir) begin
            in_d = out;
        end else if (pull_active(pull)) begin
            in_d = pull_is_up(pull);
        end
        clash = dir & ext_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= 1'b0;
        else        in_q <= in_d;
    end

    // R5: connected input follows external driver
    p_ext_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!disc && ext_en) |=> (in_q == $past(ext_val)));

    // R6: connected output sees its own level
    p_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disc && !ext_en && dir) |=> (in_q == $past(out)));

    // R8: keeper holds when nothing defines the level
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!disc && !ext_en && !dir && !pull_active(pull)) |=> (in_q == $past(in_q)));

    // R9: disconnected input shows only the pull-up
    p_disc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disc |=> (in_q == $past(pull == PULL_UP)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 6,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic [NPINS-1:0]      clash,
    output logic [NPINS-1:0]      out_q,
    output logic [NPINS-1:0]      dir_q,
    output logic [NPINS-1:0]      disc_q,
    output logic [NPINS-1:0][1:0] pull_q,
    output logic                  err_q
);
    typedef struct packed {
        logic [NPINS-1:0]      out;
        logic [NPINS-1:0]      dir;
        logic [NPINS-1:0]      disc;
        logic [NPINS-1:0][1:0] pull;
        logic                  err;
    } state_t;

    state_t s_d, s_q;

    logic [NPINS-1:0] wbits;
    logic [AW-1:0]    cfg_idx;
    logic             cfg_hit;

    assign wbits   = wr_data[NPINS-1:0];
    assign cfg_idx = wr_addr - AW'(CFG_BASE);
    assign cfg_hit = (wr_addr >= AW'(CFG_BASE)) && (cfg_idx < AW'(NPINS));

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                AW'(OFF_OUT):  s_d.out = wbits;
                AW'(OFF_OSET): s_d.out = s_q.out | wbits;
                AW'(OFF_OCLR): s_d.out = s_q.out & ~wbits;
                AW'(OFF_DIR):  s_d.dir = wbits;
                AW'(OFF_DSET): s_d.dir = s_q.dir | wbits;
                AW'(OFF_DCLR): s_d.dir = s_q.dir & ~wbits;
                AW'(OFF_ERR):  if (wr_data[0]) s_d.err = 1'b0;
                default: ;
            endcase
            for (int i = 0; i < NPINS; i++) begin
                if (cfg_hit && cfg_idx == AW'(i)) begin
                    s_d.dir[i]  = wr_data[CFG_DIR_BIT];
                    s_d.disc[i] = wr_data[CFG_DISC_BIT];
                    s_d.pull[i] = wr_data[CFG_PULL_LO+1:CFG_PULL_LO];
                end
            end
        end
        if (|clash) s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.out  <= '0;
            s_q.dir  <= '0;
            s_q.disc <= '1;
            s_q.pull <= '0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_q  = s_q.out;
    assign dir_q  = s_q.dir;
    assign disc_q = s_q.disc;
    assign pull_q = s_q.pull;
    assign err_q  = s_q.err;

    // R1: reset state
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0 && dir_q == '0 && disc_q == '1 && pull_q == '0 && !err_q));

    // R2: set alias touches only written ones
    p_oset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(OFF_OSET)) |=>
        (out_q == ($past(out_q) | $past(wbits))));

    // R2: clear alias touches only written ones
    p_oclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(OFF_OCLR)) |=>
        (out_q == ($past(out_q) & ~$past(wbits))));

    // R3: direction set alias
    p_dset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(OFF_DSET)) |=>
        (dir_q == ($past(dir_q) | $past(wbits))));

    // R10: conflict sets the error
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|clash) |=> err_q);

    // R11: error only drops on a clear write
    p_err_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_en && wr_addr == AW'(OFF_ERR) && wr_data[0])) |=> err_q);
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 6,
    parameter int DW    = 32
) (
    input  logic [AW-1:0]         addr,
    input  logic [NPINS-1:0]      out_v,
    input  logic [NPINS-1:0]      in_v,
    input  logic [NPINS-1:0]      dir_v,
    input  logic [NPINS-1:0]      disc_v,
    input  logic [NPINS-1:0][1:0] pull_v,
    input  logic                  err,
    output logic [DW-1:0]         rdata
);
    logic [AW-1:0] idx;
    logic          hit;

    assign idx = addr - AW'(CFG_BASE);
    assign hit = (addr >= AW'(CFG_BASE)) && (idx < AW'(NPINS));

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(OFF_OUT), AW'(OFF_OSET), AW'(OFF_OCLR): rdata[NPINS-1:0] = out_v;
            AW'(OFF_IN):                                rdata[NPINS-1:0] = in_v;
            AW'(OFF_DIR), AW'(OFF_DSET), AW'(OFF_DCLR): rdata[NPINS-1:0] = dir_v;
            AW'(OFF_ERR):                               rdata[0] = err;
            default: ;
        endcase
        for (int i = 0; i < NPINS; i++) begin
            if (hit && idx == AW'(i)) begin
                rdata[CFG_USED-1:0] = {pull_v[i], disc_v[i], dir_v[i]};
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NPINS-1:0] ext_drv_en,
    input  logic [NPINS-1:0] ext_drv_val,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_out,
    output logic             drive_err
);
    logic [NPINS-1:0]      out_q, dir_q, disc_q, in_v, clash_v;
    logic [NPINS-1:0][1:0] pull_q;
    logic                  err_q;

    gpio_bank_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .clash   (clash_v),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .disc_q  (disc_q),
        .pull_q  (pull_q),
        .err_q   (err_q)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir     (dir_q[g]),
            .out     (out_q[g]),
            .disc    (disc_q[g]),
            .pull    (pull_q[g]),
            .ext_en  (ext_drv_en[g]),
            .ext_val (ext_drv_val[g]),
            .in_q    (in_v[g]),
            .clash   (clash_v[g])
        );
    end

    gpio_bank_rdmux #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_rd (
        .addr   (reg_addr),
        .out_v  (out_q),
        .in_v   (in_v),
        .dir_v  (dir_q),
        .disc_v (disc_q),
        .pull_v (pull_q),
        .err    (err_q),
        .rdata  (reg_rdata)
    );

    assign pin_oe    = dir_q;
    assign pin_out   = out_q & dir_q;
    assign drive_err = err_q;

    // R10: an externally driven input never raises the flag by itself
    p_no_false_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && ((ext_drv_en & dir_q) == '0) &&
         !(reg_wr && reg_addr >= AW'(CFG_BASE)) &&
         !(reg_wr && (reg_addr == AW'(OFF_DIR) || reg_addr == AW'(OFF_DSET)))) |=> !drive_err);
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    localparam int A_OUT = 0, A_OSET = 1, A_OCLR = 2, A_IN = 3;
    localparam int A_DIR = 4, A_DSET = 5, A_DCLR = 6, A_ERR = 7, A_CFG = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] ext_drv_en = '0;
    logic [31:0] ext_drv_val = '0;
    logic [31:0] pin_oe, pin_out;
    logic        drive_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_drv_en(ext_drv_en),
        .ext_drv_val(ext_drv_val), .pin_oe(pin_oe), .pin_out(pin_out),
        .drive_err(drive_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 6'(a);
        #0.5;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_OUT, v); chk("R1 out", v, 0);
        rd(A_IN, v);  chk("R1 in", v, 0);
        rd(A_DIR, v); chk("R1 dir", v, 0);
        rd(A_ERR, v); chk("R1 err", v, 0);
        rd(A_CFG, v); chk("R1 cfg0", v, 32'h2);
        rd(A_CFG + 31, v); chk("R1 cfg31", v, 32'h2);
    endtask

    task automatic t_out();
        logic [31:0] v;
        wr(A_OUT, 32'h0000_00A5);
        wr(A_OSET, 32'h0F00_0001);
        rd(A_OSET, v); chk("R2 set", v, 32'h0F00_00A5);
        wr(A_OCLR, 32'h0000_0081);
        rd(A_OCLR, v); chk("R2 clr", v, 32'h0F00_0024);
        rd(A_OUT, v);  chk("R2 out", v, 32'h0F00_0024);
        wr(A_OUT, 0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        wr(A_DSET, 32'h8000_0001);
        rd(A_DIR, v); chk("R3 dirset", v, 32'h8000_0001);
        rd(A_CFG, v); chk("R3 cfg0 after set", v, 32'h3);
        rd(A_CFG + 31, v); chk("R3 cfg31 after set", v, 32'h3);
        wr(A_DCLR, 32'h8000_0001);
        rd(A_DCLR, v); chk("R3 dirclr", v, 0);
        rd(A_CFG + 31, v); chk("R3 cfg31 after clr", v, 32'h2);
        wr(A_DIR, 32'h8000_0001);
        rd(A_CFG, v); chk("R3 cfg0 after dir", v, 32'h3);
        wr(A_DIR, 0);
        wr(A_CFG + 5, 32'h1);
        rd(A_DSET, v); chk("R3 dir from cfg", v, 32'h0000_0020);
        wr(A_CFG + 5, 32'h2);
    endtask

    task automatic t_cfg_upper();
        logic [31:0] v;
        wr(A_CFG + 3, 32'hFFFF_FFF0);
        rd(A_CFG + 3, v); chk("R12 upper ignored", v, 0);
        wr(A_CFG + 3, 32'hFFFF_FFFE);
        rd(A_CFG + 3, v); chk("R12 low kept", v, 32'hE);
        rd(A_DIR, v); chk("R12 dir untouched", v, 0);
        wr(A_CFG + 3, 32'h2);
    endtask

    task automatic t_pinout();
        wr(A_CFG, 32'h3);
        wr(A_OSET, 32'h3);
        #0.5;
        chk("R4 oe", pin_oe, 32'h1);
        chk("R4 out high", pin_out, 32'h1);
        wr(A_OCLR, 32'h1);
        #0.5;
        chk("R4 out low, input pin masked", pin_out, 0);
        wr(A_OUT, 0);
        wr(A_CFG, 32'h2);
    endtask

    task automatic t_ext_keep();
        logic [31:0] v;
        wr(A_CFG, 32'h0);
        @(negedge clk); ext_drv_en = 32'h1; ext_drv_val = 0;
        settle(); rd(A_IN, v); chk("R5 ext low", v, 0);
        ext_drv_val = 32'h1;
        settle(); rd(A_IN, v); chk("R5 ext high", v, 32'h1);
        ext_drv_en = 0;
        repeat (4) @(negedge clk);
        rd(A_IN, v); chk("R8 keeper holds 1", v, 32'h1);
        ext_drv_en = 32'h1; ext_drv_val = 0;
        settle(); ext_drv_en = 0;
        settle(); rd(A_IN, v); chk("R8 keeper holds 0", v, 0);
    endtask

    task automatic t_pull();
        logic [31:0] v;
        wr(A_CFG, 32'hC);
        settle(); rd(A_IN, v); chk("R7 pull-up", v, 32'h1);
        wr(A_CFG, 32'h4);
        settle(); rd(A_IN, v); chk("R7 pull-down", v, 0);
        wr(A_CFG, 32'hC);
        settle();
        wr(A_CFG, 32'h8);
        settle(); rd(A_IN, v); chk("R7 code 2 is no pull", v, 32'h1);
    endtask

    task automatic t_disc();
        logic [31:0] v;
        @(negedge clk); ext_drv_en = 32'h1; ext_drv_val = 0;
        wr(A_CFG, 32'hE);
        settle(); rd(A_IN, v); chk("R9 disc pull-up", v, 32'h1);
        ext_drv_val = 32'h1;
        wr(A_CFG, 32'h6);
        settle(); rd(A_IN, v); chk("R9 disc pull-down", v, 0);
        wr(A_CFG, 32'h2);
        settle(); rd(A_IN, v); chk("R9 disc no pull", v, 0);
        ext_drv_en = 0;
    endtask

    task automatic t_self();
        logic [31:0] v;
        wr(A_CFG, 32'h1);
        wr(A_OSET, 32'h1);
        settle(); rd(A_IN, v); chk("R6 own high", v, 32'h1);
        wr(A_OCLR, 32'h1);
        settle(); rd(A_IN, v); chk("R6 own low", v, 0);
    endtask

    task automatic t_conflict();
        logic [31:0] v;
        wr(A_CFG, 32'h0);
        @(negedge clk); ext_drv_en = 32'h1; ext_drv_val = 32'h1;
        settle(); rd(A_ERR, v); chk("R10 input drive no error", v, 0);
        wr(A_CFG, 32'h1);
        settle(); rd(A_ERR, v); chk("R10 conflict", v, 32'h1);
        wr(A_ERR, 32'h1);
        rd(A_ERR, v); chk("R11 set beats clear", v, 32'h1);
        ext_drv_en = 0;
        settle(); chk("R10 sticky port", {31'b0, drive_err}, 32'h1);
        wr(A_ERR, 32'h0);
        rd(A_ERR, v); chk("R11 write 0 keeps", v, 32'h1);
        wr(A_ERR, 32'h1);
        rd(A_ERR, v); chk("R11 clear", v, 0);
        wr(A_CFG, 32'h2);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_out();
        t_dir();
        t_cfg_upper();
        t_pinout();
        t_ext_keep();
        t_pull();
        t_disc();
        t_self();
        t_conflict();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule